// File: doc/BRIEF.md
# Serial Receive Buffer and Error Status

This block is the receive side of an asynchronous serial port, placed after a bit-recovery front end. For every completed frame, the front end raises a one-cycle strobe that carries the data byte, the received parity bit and the sample of the first stop bit. The block then either loads the byte into a receive buffer register or discards it. At the same time it records parity, framing and overrun errors in a status register that software can only read.

Software reads both registers through a simple read port with a one-bit register select. A read of the status register returns the current flags and clears them. A read of the buffer frees the buffer for the next frame. While the port is powered down or its receiver is disabled, incoming frames are ignored and all error flags are held at zero.

Top module: `rx_err_status`

## Requirements
- R1: After reset the buffer reads 00h and the status register reads 00h. The status register places the parity error at bit 2, the framing error at bit 1 and the overrun error at bit 0, and its bits 7 to 3 always read 0.
- R2: A status read returns the flags as they were before the read, and the flags are 0 from the next cycle on, unless a new error arrives in that same cycle.
- R3: While `pwrEn` or `rxEn` is 0, all flags are forced to 0. A frame strobe in that state neither loads the buffer nor sets any flag nor marks the buffer full.
- R4: `paritySel` selects the parity check: 00 is none (the parity flag is never set), 01 is zero (a parity bit of 1 is an error), 10 is odd (an error when data plus parity hold an even count of ones) and 11 is even (an error when that count is odd).
- R5: The framing flag is set when the first stop bit sample is 0. No other stop bit is examined.
- R6: A frame that completes while the buffer is full, with no buffer read in the same cycle, sets the overrun flag. Its byte is discarded and the buffer keeps its earlier value.
- R7: Loading a frame marks the buffer full, and a buffer read marks it empty. A buffer read in the same cycle as a frame strobe returns the old byte, and the new frame is accepted without an overrun.
- R8: Flags are sticky. A repeated error, or a later frame without errors, leaves a set flag set until it is cleared by a status read or by disabling.
- R9: When a status read and a new error fall in the same cycle, the read returns the old flags and the new error stays set afterwards.
- R10: `rdData` is combinational. With `rdEn` at 1, `rdAddr` 0 selects the buffer and 1 selects the status register. With `rdEn` at 0, `rdData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwrEn | input | 1 | Port power enable |
| rxEn | input | 1 | Receiver enable |
| paritySel | input | 2 | Parity check mode |
| frameDone | input | 1 | One-cycle strobe marking a completed frame |
| frameData | input | 8 | Received data byte |
| frameParity | input | 1 | Received parity bit |
| frameStop | input | 1 | Sample of the first stop bit |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | 1 | Register select: 0 buffer, 1 status |
| rdData | output | 8 | Read data |

## Verification
The assertions assume that `frameDone` is a pulse lasting one clock, with its data, parity and stop inputs valid in that cycle. They also assume that each `rdEn` cycle counts as exactly one register access, so that a read held for two cycles clears twice. The bench keeps within these assumptions by changing every input on the falling clock edge, raising `frameDone` and `rdEn` for exactly one cycle at a time, and applying enable changes only between frames or as deliberate single-cycle drops. It sweeps every data byte against every parity mode, parity bit and stop sample, and then drives the same-cycle collisions between reads and frame strobes directly.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } parMode_e;

  localparam int FLAG_W = 3;
  localparam int PE_BIT = 2;
  localparam int FE_BIT = 1;
  localparam int OV_BIT = 0;

  typedef struct packed {
    logic loadBuf;
    logic setPe;
    logic setFe;
    logic setOve;
    logic clrRead;
    logic clrOff;
  } rxStrobe_t;

endpackage

// File: rtl/rx_err_ctrl.sv
module rx_err_ctrl
  import rx_err_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrEn,
  input  logic              rxEn,
  input  logic [1:0]        paritySel,
  input  logic              frameDone,
  input  logic [DATA_W-1:0] frameData,
  input  logic              frameParity,
  input  logic              frameStop,
  input  logic              bufRead,
  input  logic              statRead,
  output rxStrobe_t         strb
);

  logic enabled;
  logic frameOk;
  logic dataOdd;
  logic parErr;
  logic overrun;
  logic bufFull;

  assign enabled = pwrEn & rxEn;
  assign frameOk = frameDone & enabled;
  assign dataOdd = ^frameData;

  always_comb begin
    case (parMode_e'(paritySel))
      PAR_NONE: parErr = 1'b0;
      PAR_ZERO: parErr = frameParity;
      PAR_ODD:  parErr = ~(dataOdd ^ frameParity);
      PAR_EVEN: parErr = dataOdd ^ frameParity;
      default:  parErr = 1'b0;
    endcase
  end

  // a buffer read in the same cycle frees the slot for the incoming frame
  assign overrun = frameOk & bufFull & ~bufRead;

  always_comb begin
    strb.loadBuf = frameOk & ~overrun;
    strb.setPe   = frameOk & parErr;
    strb.setFe   = frameOk & ~frameStop;
    strb.setOve  = overrun;
    strb.clrRead = statRead;
    strb.clrOff  = ~enabled;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufFull <= 1'b0;
    end else if (strb.loadBuf) begin
      bufFull <= 1'b1;
    end else if (bufRead) begin
      bufFull <= 1'b0;
    end
  end

  assert_par_none_quiet_R4 : assert property (@(posedge clk) disable iff (!rstN)
    (paritySel == 2'b00) |-> !strb.setPe);

  assert_full_flags_overrun_R6 : assert property (@(posedge clk) disable iff (!rstN)
    (bufFull && frameDone && enabled && !bufRead) |-> (strb.setOve && !strb.loadBuf));

endmodule

// File: rtl/rx_err_datapath.sv
module rx_err_datapath
  import rx_err_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  logic [DATA_W-1:0] frameData,
  output logic [DATA_W-1:0] rxBuf,
  output logic [FLAG_W-1:0] flags
);

  logic [FLAG_W-1:0] setVec;

  always_comb begin
    setVec         = '0;
    setVec[PE_BIT] = strb.setPe;
    setVec[FE_BIT] = strb.setFe;
    setVec[OV_BIT] = strb.setOve;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxBuf <= '0;
    end else if (strb.loadBuf) begin
      rxBuf <= frameData;
    end
  end

  assert_overrun_keeps_buffer_R6 : assert property (@(posedge clk) disable iff (!rstN)
    strb.setOve |=> $stable(rxBuf));

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    // disable wins, then a new error, then clear-on-read
    always_ff @(posedge clk) begin
      if (!rstN) begin
        flags[i] <= 1'b0;
      end else if (strb.clrOff) begin
        flags[i] <= 1'b0;
      end else if (setVec[i]) begin
        flags[i] <= 1'b1;
      end else if (strb.clrRead) begin
        flags[i] <= 1'b0;
      end
    end

    assert_flag_sticky_R8 : assert property (@(posedge clk) disable iff (!rstN)
      (flags[i] && !strb.clrRead && !strb.clrOff) |=> flags[i]);
  end

endmodule

// File: rtl/rx_err_status.sv
module rx_err_status
  import rx_err_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 1,
  parameter int BUF_ADDR  = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrEn,
  input  logic              rxEn,
  input  logic [1:0]        paritySel,
  input  logic              frameDone,
  input  logic [DATA_W-1:0] frameData,
  input  logic              frameParity,
  input  logic              frameStop,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam int PAD_W = DATA_W - FLAG_W;

  rxStrobe_t         strb;
  logic [DATA_W-1:0] rxBuf;
  logic [FLAG_W-1:0] statusFlags;
  logic              bufRead;
  logic              statRead;

  assign bufRead  = rdEn && (rdAddr == ADDR_W'(BUF_ADDR));
  assign statRead = rdEn && (rdAddr == ADDR_W'(STAT_ADDR));

  rx_err_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pwrEn      (pwrEn),
    .rxEn       (rxEn),
    .paritySel  (paritySel),
    .frameDone  (frameDone),
    .frameData  (frameData),
    .frameParity(frameParity),
    .frameStop  (frameStop),
    .bufRead    (bufRead),
    .statRead   (statRead),
    .strb       (strb)
  );

  rx_err_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .frameData(frameData),
    .rxBuf    (rxBuf),
    .flags    (statusFlags)
  );

  always_comb begin
    rdData = '0;
    if (bufRead) begin
      rdData = rxBuf;
    end else if (statRead) begin
      rdData = {{PAD_W{1'b0}}, statusFlags};
    end
  end

  assert_read_clears_R2 : assert property (@(posedge clk) disable iff (!rstN)
    (statRead && !(frameDone && pwrEn && rxEn)) |=> (statusFlags == '0));

  assert_disabled_clear_R3 : assert property (@(posedge clk) disable iff (!rstN)
    !(pwrEn && rxEn) |=> (statusFlags == '0));

  assert_stop_low_frames_R5 : assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && pwrEn && rxEn && !frameStop) |=> statusFlags[FE_BIT]);

  assert_idle_port_zero_R10 : assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> (rdData == '0));

endmodule

// File: tb/rx_err_status_tb.sv
module rx_err_status_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwrEn = 1'b1;
  logic       rxEn = 1'b1;
  logic [1:0] paritySel = 2'b00;
  logic       frameDone = 1'b0;
  logic [7:0] frameData = 8'h00;
  logic       frameParity = 1'b0;
  logic       frameStop = 1'b1;
  logic       rdEn = 1'b0;
  logic [0:0] rdAddr = 1'b0;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rx_err_status u_dut (
    .clk(clk), .rstN(rstN), .pwrEn(pwrEn), .rxEn(rxEn), .paritySel(paritySel),
    .frameDone(frameDone), .frameData(frameData), .frameParity(frameParity),
    .frameStop(frameStop), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic p, input logic s);
    @(negedge clk);
    frameDone = 1'b1; frameData = d; frameParity = p; frameStop = s;
    @(negedge clk);
    frameDone = 1'b0;
  endtask

  task automatic readReg(input logic a, output logic [7:0] v);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = a;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  function automatic logic expPar(input logic [1:0] m, input logic [7:0] d, input logic p);
    case (m)
      2'b00:   return 1'b0;
      2'b01:   return p;
      2'b10:   return ~((^d) ^ p);
      default: return (^d) ^ p;
    endcase
  endfunction

  logic [7:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 / R10: reset state and idle port
    #1 chk("R10 idle read", rdData, 8'h00);
    readReg(1'b0, v); chk("R1 buffer reset", v, 8'h00);
    readReg(1'b1, v); chk("R1 status reset", v, 8'h00);

    // R4 / R5 / R7: sweep of every mode, byte, parity bit and stop sample
    for (int m = 0; m < 4; m++) begin
      paritySel = 2'(m);
      for (int d = 0; d < 256; d++) begin
        for (int p = 0; p < 2; p++) begin
          for (int s = 0; s < 2; s++) begin
            sendFrame(8'(d), 1'(p), 1'(s));
            readReg(1'b1, v);
            chk("R4 R5 status", v, {5'b0, expPar(2'(m), 8'(d), 1'(p)), ~1'(s), 1'b0});
            readReg(1'b0, v);
            chk("R7 buffer load", v, 8'(d));
          end
        end
      end
    end
    paritySel = 2'b00;

    // R6: overrun discards the new byte
    sendFrame(8'h3C, 1'b0, 1'b1);
    sendFrame(8'hC3, 1'b0, 1'b1);
    readReg(1'b1, v); chk("R6 overrun flag", v, 8'h01);
    readReg(1'b0, v); chk("R6 buffer kept", v, 8'h3C);
    sendFrame(8'h5A, 1'b0, 1'b1);
    readReg(1'b1, v); chk("R7 no overrun after read", v, 8'h00);
    readReg(1'b0, v); chk("R7 new byte loaded", v, 8'h5A);

    // R8 / R2: sticky flags and clear on read
    paritySel = 2'b01;
    sendFrame(8'h11, 1'b1, 1'b1);
    readReg(1'b0, v);
    sendFrame(8'h22, 1'b1, 1'b1);
    readReg(1'b1, v); chk("R8 repeated error", v, 8'h04);
    readReg(1'b1, v); chk("R2 cleared by read", v, 8'h00);
    readReg(1'b0, v);
    sendFrame(8'h33, 1'b1, 1'b1);
    readReg(1'b0, v);
    sendFrame(8'h44, 1'b0, 1'b1);
    readReg(1'b1, v); chk("R8 survives clean frame", v, 8'h04);
    readReg(1'b0, v);
    paritySel = 2'b00;

    // R7: buffer read in the same cycle as a frame
    sendFrame(8'h77, 1'b0, 1'b1);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = 1'b0;
    frameDone = 1'b1; frameData = 8'h88; frameParity = 1'b0; frameStop = 1'b1;
    #1 chk("R7 same-cycle old byte", rdData, 8'h77);
    @(negedge clk);
    rdEn = 1'b0; frameDone = 1'b0;
    readReg(1'b1, v); chk("R7 same-cycle no overrun", v, 8'h00);
    readReg(1'b0, v); chk("R7 same-cycle new byte", v, 8'h88);

    // R9: status read collides with a framing error
    @(negedge clk);
    rdEn = 1'b1; rdAddr = 1'b1;
    frameDone = 1'b1; frameData = 8'h99; frameParity = 1'b0; frameStop = 1'b0;
    #1 chk("R9 read returns old flags", rdData, 8'h00);
    @(negedge clk);
    rdEn = 1'b0; frameDone = 1'b0;
    readReg(1'b1, v); chk("R9 new error kept", v, 8'h02);
    readReg(1'b0, v); chk("R9 buffer", v, 8'h99);

    // R3: receiver disable and power-down clear flags
    sendFrame(8'h10, 1'b0, 1'b0);
    readReg(1'b0, v);
    @(negedge clk); rxEn = 1'b0;
    @(negedge clk); rxEn = 1'b1;
    readReg(1'b1, v); chk("R3 rx disable clears", v, 8'h00);
    sendFrame(8'h20, 1'b0, 1'b0);
    readReg(1'b0, v);
    @(negedge clk); pwrEn = 1'b0;
    @(negedge clk); pwrEn = 1'b1;
    readReg(1'b1, v); chk("R3 power-down clears", v, 8'h00);

    // R3: frame while disabled is ignored
    paritySel = 2'b01;
    @(negedge clk); rxEn = 1'b0;
    sendFrame(8'hEE, 1'b1, 1'b0);
    @(negedge clk); rxEn = 1'b1;
    readReg(1'b1, v); chk("R3 disabled frame no flags", v, 8'h00);
    readReg(1'b0, v); chk("R3 disabled frame not loaded", v, 8'h20);
    paritySel = 2'b00;
    sendFrame(8'h30, 1'b0, 1'b1);
    readReg(1'b1, v); chk("R3 buffer not marked full", v, 8'h00);
    readReg(1'b0, v); chk("R3 later frame loads", v, 8'h30);

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule